// File: doc/BRIEF.md
# Reorder-Buffer Memory Ordering Gate

This block sits beside a reorder buffer and decides, every cycle, which in-flight memory operations may proceed. It inspects each buffer slot (occupied flag, operation kind, whether the effective address is known, whether the memory access has finished, and the address itself) together with the head pointer. From these it works out which loads may start their memory access, which loads may compute their effective address, and whether the store sitting at the head may write memory.

Stores only ever write from the head slot, so memory is updated in program order. That leaves only read-after-write ordering to police for loads. A load is held back by any older unfinished store whose word address matches its own, or whose address is still unknown. It is also held back by any older fence still in the buffer. Age is measured as the distance from the head around the circular buffer. The granted loads are reported as a vector, and the oldest of them is also reported as an index. All outputs are registered and appear one cycle after the inputs that produced them.

Top module: `rob_mem_gate`

## Requirements
- R1: While reset is low and in the cycle after, every grant output, `agen_ok`, `first_valid` and `first_idx` are zero.
- R2: `store_commit` is 1 exactly when the head slot is occupied, has kind store (2'b10), has a known address and is not done. No other slot can ever be committed.
- R3: A load is not granted while an older occupied store that is not done has a known address whose word address (bits AW-1:2) equals the load's word address.
- R4: Addresses that differ only in bits 1:0 count as a match. Addresses that differ in any bit from 2 upward do not.
- R5: An older occupied, not-done store with an unknown address blocks every younger load.
- R6: Only older slots block. A slot is older when its distance from the head, (index - head) mod DEPTH, is smaller, including across wraparound. Younger stores and stores that are done never block.
- R7: An occupied fence (kind 2'b11) blocks every load younger than it. A fence younger than the load does not block it.
- R8: `agen_ok[i]` is 1 exactly when slot i is an occupied, not-done load (kind 2'b01) whose address is unknown and no older occupied, not-done store has an unknown address.
- R9: `first_valid` is 1 when any load is granted. `first_idx` is then the granted slot closest to the head.
- R10: A load is granted only if its slot is occupied, has kind load, has a known address and is not done. Other (2'b00) slots never receive a grant.
- R11: Outputs reflect the inputs sampled at the previous rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ent_valid | input | DEPTH | Slot occupied |
| ent_kind | input | 2*DEPTH | Per-slot kind: 00 other, 01 load, 10 store, 11 fence |
| ent_addr_ok | input | DEPTH | Effective address known |
| ent_done | input | DEPTH | Memory access finished |
| ent_addr | input | AW*DEPTH | Per-slot effective address |
| head | input | log2(DEPTH) | Index of the oldest slot |
| load_grant | output | DEPTH | Load may start its memory access |
| agen_ok | output | DEPTH | Load may compute its effective address |
| store_commit | output | 1 | Store at the head may write memory |
| first_valid | output | 1 | At least one load granted |
| first_idx | output | log2(DEPTH) | Oldest granted load |

## Verification
A head store commit and load grants can occur in the same cycle. The head store must commit while a younger load to a different word is released, and a younger load to the same word must be held. The bench provokes this with directed cases that put a store at the head and loads behind it with matching and non-matching words. It also runs random buffers whose addresses come from a small pool, so overlaps are frequent. Each cycle the commit bit, the grant vector and the oldest-pick index are compared together against a reference model that works from the requirements.

// File: rtl/rob_mem_pkg.sv
// Shared kind encoding for reorder-buffer memory ordering.
// Assumes two bits per slot; values are fixed by the producer of ent_kind.
package rob_mem_pkg;
    typedef enum logic [1:0] {
        KIND_OTHER = 2'b00,
        KIND_LOAD  = 2'b01,
        KIND_STORE = 2'b10,
        KIND_FENCE = 2'b11
    } mem_kind_e;
endpackage

// File: rtl/rob_age_rank.sv
// Converts each slot index into its distance from the head pointer.
// Assumes DEPTH is a power of two so the subtraction wraps naturally.
module rob_age_rank #(
    parameter int DEPTH = 8,
    localparam int IDXW = $clog2(DEPTH)
) (
    input  logic [IDXW-1:0]       head,
    output logic [IDXW*DEPTH-1:0] rank
);
    for (genvar i = 0; i < DEPTH; i++) begin : g_rank
        localparam logic [IDXW-1:0] SLOT = IDXW'(i);
        // Distance of slot i from the head, modulo DEPTH.
        always_comb rank[i*IDXW +: IDXW] = SLOT - head;
    end
endmodule

// File: rtl/rob_load_gate.sv
// Per-slot load permission logic. A load is released for memory access
// when no older unfinished store could alias it and no older fence is
// present. Address generation is allowed once all older stores have known
// addresses. Assumes rank gives each slot's distance from the head.
module rob_load_gate
    import rob_mem_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int AW    = 32,
    localparam int IDXW = $clog2(DEPTH),
    localparam int WLSB = 2
) (
    input  logic [DEPTH-1:0]      ent_valid,
    input  logic [2*DEPTH-1:0]    ent_kind,
    input  logic [DEPTH-1:0]      ent_addr_ok,
    input  logic [DEPTH-1:0]      ent_done,
    input  logic [AW*DEPTH-1:0]   ent_addr,
    input  logic [IDXW*DEPTH-1:0] rank,
    output logic [DEPTH-1:0]      grant,
    output logic [DEPTH-1:0]      agen
);
    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        logic is_load;
        logic any_block;
        logic any_unknown;

        // Scan every other slot for an older hazard against slot i.
        always_comb begin
            is_load     = ent_valid[i] && !ent_done[i] &&
                          (mem_kind_e'(ent_kind[2*i +: 2]) == KIND_LOAD);
            any_block   = 1'b0;
            any_unknown = 1'b0;
            for (int j = 0; j < DEPTH; j++) begin
                logic older;
                logic st_live;
                older   = rank[j*IDXW +: IDXW] < rank[i*IDXW +: IDXW];
                st_live = ent_valid[j] && !ent_done[j] &&
                          (mem_kind_e'(ent_kind[2*j +: 2]) == KIND_STORE);
                if (older && ent_valid[j] &&
                    mem_kind_e'(ent_kind[2*j +: 2]) == KIND_FENCE)
                    any_block = 1'b1;
                if (older && st_live && !ent_addr_ok[j]) begin
                    any_block   = 1'b1;
                    any_unknown = 1'b1;
                end
                if (older && st_live && ent_addr_ok[j] &&
                    ent_addr[j*AW+WLSB +: AW-WLSB] == ent_addr[i*AW+WLSB +: AW-WLSB])
                    any_block = 1'b1;
            end
        end

        // Final permission bits for slot i.
        always_comb begin
            grant[i] = is_load && ent_addr_ok[i] && !any_block;
            agen[i]  = is_load && !ent_addr_ok[i] && !any_unknown;
        end
    end
endmodule

// File: rtl/rob_oldest_pick.sv
// Chooses the granted slot with the smallest distance from the head.
// Assumes rank values are distinct (a permutation of 0..DEPTH-1).
module rob_oldest_pick #(
    parameter int DEPTH = 8,
    localparam int IDXW = $clog2(DEPTH)
) (
    input  logic [DEPTH-1:0]      req,
    input  logic [IDXW*DEPTH-1:0] rank,
    output logic                  any,
    output logic [IDXW-1:0]       idx
);
    // Linear scan keeping the requester with the lowest rank.
    always_comb begin
        logic [IDXW-1:0] best_rank;
        any       = 1'b0;
        idx       = '0;
        best_rank = '1;
        for (int i = 0; i < DEPTH; i++) begin
            if (req[i] && (!any || rank[i*IDXW +: IDXW] < best_rank)) begin
                any       = 1'b1;
                idx       = IDXW'(i);
                best_rank = rank[i*IDXW +: IDXW];
            end
        end
    end
endmodule

// File: rtl/rob_mem_gate.sv
// Memory ordering gate for a reorder buffer. Releases loads that cannot
// alias an older store, permits a store to write only from the head slot,
// and holds loads behind older fences. All outputs are registered.
// Assumes DEPTH is a power of two and the head slot is the oldest.
module rob_mem_gate
    import rob_mem_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int AW    = 32,
    localparam int IDXW = $clog2(DEPTH)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [DEPTH-1:0]      ent_valid,
    input  logic [2*DEPTH-1:0]    ent_kind,
    input  logic [DEPTH-1:0]      ent_addr_ok,
    input  logic [DEPTH-1:0]      ent_done,
    input  logic [AW*DEPTH-1:0]   ent_addr,
    input  logic [IDXW-1:0]       head,
    output logic [DEPTH-1:0]      load_grant,
    output logic [DEPTH-1:0]      agen_ok,
    output logic                  store_commit,
    output logic                  first_valid,
    output logic [IDXW-1:0]       first_idx
);
    logic [IDXW*DEPTH-1:0] rank;
    logic [DEPTH-1:0]      grant_c;
    logic [DEPTH-1:0]      agen_c;
    logic                  pick_any;
    logic [IDXW-1:0]       pick_idx;
    logic                  commit_c;

    rob_age_rank #(.DEPTH(DEPTH)) u_rank (.head(head), .rank(rank));

    rob_load_gate #(.DEPTH(DEPTH), .AW(AW)) u_gate (
        .ent_valid(ent_valid), .ent_kind(ent_kind), .ent_addr_ok(ent_addr_ok),
        .ent_done(ent_done), .ent_addr(ent_addr), .rank(rank),
        .grant(grant_c), .agen(agen_c)
    );

    rob_oldest_pick #(.DEPTH(DEPTH)) u_pick (
        .req(grant_c), .rank(rank), .any(pick_any), .idx(pick_idx)
    );

    // Head store may write when its address is known and it is unfinished.
    always_comb commit_c = ent_valid[head] && ent_addr_ok[head] && !ent_done[head] &&
                           (mem_kind_e'(ent_kind[2*head +: 2]) == KIND_STORE);

    // Register all decisions; reset clears them.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            load_grant   <= '0;
            agen_ok      <= '0;
            store_commit <= 1'b0;
            first_valid  <= 1'b0;
            first_idx    <= '0;
        end else begin
            load_grant   <= grant_c;
            agen_ok      <= agen_c;
            store_commit <= commit_c;
            first_valid  <= pick_any;
            first_idx    <= pick_idx;
        end
    end
endmodule

// File: rtl/rob_mem_gate_chk.sv
// Assertion checker for rob_mem_gate, attached by bind below.
module rob_mem_gate_chk #(
    parameter int DEPTH = 8,
    parameter int AW    = 32,
    localparam int IDXW = $clog2(DEPTH)
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic [DEPTH-1:0]      ent_valid,
    input logic [2*DEPTH-1:0]    ent_kind,
    input logic [DEPTH-1:0]      ent_addr_ok,
    input logic [DEPTH-1:0]      ent_done,
    input logic [AW*DEPTH-1:0]   ent_addr,
    input logic [IDXW-1:0]       head,
    input logic [DEPTH-1:0]      load_grant,
    input logic [DEPTH-1:0]      agen_ok,
    input logic                  store_commit,
    input logic                  first_valid,
    input logic [IDXW-1:0]       first_idx
);
    logic head_store;
    always_comb head_store = ent_valid[head] && (ent_kind[2*head +: 2] == 2'b10);

    assert_reset_quiet_R1: assert property (@(posedge clk)
        !rst_n |=> (load_grant == '0 && agen_ok == '0 && !store_commit && !first_valid));

    assert_commit_head_R2: assert property (@(posedge clk) disable iff (!rst_n)
        store_commit |-> $past(head_store));

    assert_grant_known_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (load_grant & ~$past(ent_valid & ent_addr_ok & ~ent_done)) == '0);

    assert_agen_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (agen_ok & load_grant) == '0);

    assert_pick_granted_R9: assert property (@(posedge clk) disable iff (!rst_n)
        first_valid |-> load_grant[first_idx]);

    assert_pick_any_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (load_grant != '0) |-> first_valid);
endmodule

bind rob_mem_gate rob_mem_gate_chk #(.DEPTH(DEPTH), .AW(AW)) u_chk (.*);

// File: tb/tb_rob_mem_gate.sv
module tb_rob_mem_gate;
    localparam int DEPTH = 8;
    localparam int AW    = 32;
    localparam int IDXW  = 3;

    logic                  clk = 1'b0;
    logic                  rst_n = 1'b0;
    logic [DEPTH-1:0]      ent_valid = '0;
    logic [2*DEPTH-1:0]    ent_kind = '0;
    logic [DEPTH-1:0]      ent_addr_ok = '0;
    logic [DEPTH-1:0]      ent_done = '0;
    logic [AW*DEPTH-1:0]   ent_addr = '0;
    logic [IDXW-1:0]       head = '0;
    logic [DEPTH-1:0]      load_grant;
    logic [DEPTH-1:0]      agen_ok;
    logic                  store_commit;
    logic                  first_valid;
    logic [IDXW-1:0]       first_idx;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    rob_mem_gate #(.DEPTH(DEPTH), .AW(AW)) dut (.*);

    function automatic int age(int i);
        return (i - int'(head)) & (DEPTH - 1);
    endfunction

    function automatic logic [1:0] kd(int i);
        return ent_kind[2*i +: 2];
    endfunction

    function automatic logic live_store(int j);
        return ent_valid[j] && !ent_done[j] && kd(j) == 2'b10;
    endfunction

    function automatic logic [DEPTH-1:0] m_grant();
        logic [DEPTH-1:0] r = '0;
        for (int i = 0; i < DEPTH; i++) begin
            logic ok = ent_valid[i] && !ent_done[i] && kd(i) == 2'b01 && ent_addr_ok[i];
            for (int j = 0; j < DEPTH; j++) begin
                if (age(j) < age(i)) begin
                    if (ent_valid[j] && kd(j) == 2'b11) ok = 1'b0;
                    if (live_store(j) && !ent_addr_ok[j]) ok = 1'b0;
                    if (live_store(j) && ent_addr_ok[j] &&
                        ent_addr[j*AW+2 +: AW-2] == ent_addr[i*AW+2 +: AW-2]) ok = 1'b0;
                end
            end
            r[i] = ok;
        end
        return r;
    endfunction

    function automatic logic [DEPTH-1:0] m_agen();
        logic [DEPTH-1:0] r = '0;
        for (int i = 0; i < DEPTH; i++) begin
            logic ok = ent_valid[i] && !ent_done[i] && kd(i) == 2'b01 && !ent_addr_ok[i];
            for (int j = 0; j < DEPTH; j++)
                if (age(j) < age(i) && live_store(j) && !ent_addr_ok[j]) ok = 1'b0;
            r[i] = ok;
        end
        return r;
    endfunction

    function automatic logic m_commit();
        return live_store(int'(head)) && ent_addr_ok[head];
    endfunction

    function automatic int m_first(logic [DEPTH-1:0] g);
        for (int a = 0; a < DEPTH; a++)
            if (g[(a + int'(head)) & (DEPTH-1)]) return (a + int'(head)) & (DEPTH-1);
        return -1;
    endfunction

    task automatic chk(string req, string what, longint act, longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic clear_all();
        ent_valid = '0; ent_kind = '0; ent_addr_ok = '0; ent_done = '0; ent_addr = '0; head = '0;
    endtask

    task automatic put(int i, logic [1:0] k, logic ok, logic [AW-1:0] a);
        ent_valid[i] = 1'b1; ent_kind[2*i +: 2] = k; ent_addr_ok[i] = ok;
        ent_done[i] = 1'b0; ent_addr[i*AW +: AW] = a;
    endtask

    // Inputs are set after a falling edge; this captures and samples after the rise (R11).
    task automatic step();
        @(posedge clk); #1;
    endtask

    // Compare every output with the reference model for the current inputs.
    task automatic model_check(string req);
        logic [DEPTH-1:0] g = m_grant();
        logic [DEPTH-1:0] ag = m_agen();
        logic c = m_commit();
        int f = m_first(g);
        step();
        chk(req, "load_grant", load_grant, g);
        chk(req, "agen_ok", agen_ok, ag);
        chk(req, "store_commit", store_commit, c);
        chk(req, "first", first_valid ? first_idx : -1, f);
        @(negedge clk);
    endtask

    initial begin
        #2_000_000;
        fails++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", checks - fails + 1, checks + 1);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        // R1: drive busy inputs while in reset
        put(0, 2'b10, 1, 32'h100); put(1, 2'b01, 1, 32'h200);
        repeat (3) @(posedge clk);
        #1;
        chk("R1", "load_grant", load_grant, 0);
        chk("R1", "store_commit", store_commit, 0);
        chk("R1", "first_valid", first_valid, 0);
        @(negedge clk); rst_n = 1'b1;

        // R2 + R3 in one cycle: head store commits, same-word load held, other load free
        clear_all(); head = 3'd2;
        put(2, 2'b10, 1, 32'h100); put(3, 2'b01, 1, 32'h100); put(4, 2'b01, 1, 32'h180);
        step();
        chk("R2", "store_commit", store_commit, 1);
        chk("R3", "load_grant", load_grant, 8'b0001_0000);
        chk("R9", "first_idx", first_idx, 4);
        @(negedge clk);

        // R11: a new input shows up only after the next edge
        ent_done[2] = 1'b1;
        #1 chk("R11", "store_commit held", store_commit, 1);
        step();
        chk("R11", "store_commit", store_commit, 0);
        chk("R6", "done store no block", load_grant, 8'b0001_1000);
        @(negedge clk);

        // R4: byte offsets within a word match, next word does not
        clear_all();
        put(0, 2'b10, 1, 32'h100); put(1, 2'b01, 1, 32'h103); put(2, 2'b01, 1, 32'h104);
        step(); chk("R4", "load_grant", load_grant, 8'b0000_0100); @(negedge clk);

        // R5 + R8: unknown older store blocks loads and address generation
        clear_all();
        put(0, 2'b10, 0, 0); put(1, 2'b01, 1, 32'h40); put(2, 2'b01, 0, 0);
        step();
        chk("R5", "load_grant", load_grant, 0);
        chk("R8", "agen_ok", agen_ok, 0);
        @(negedge clk);
        ent_addr_ok[0] = 1'b1; ent_addr[0 +: AW] = 32'h80;
        step();
        chk("R8", "agen_ok", agen_ok, 8'b0000_0100);
        chk("R5", "load_grant", load_grant, 8'b0000_0010);
        chk("R2", "store_commit", store_commit, 1);
        @(negedge clk);

        // R6: wraparound, slot 7 older than slot 1 with head 6; younger store ignored
        clear_all(); head = 3'd6;
        put(7, 2'b10, 1, 32'h300); put(1, 2'b01, 1, 32'h300);
        put(0, 2'b01, 1, 32'h500); put(2, 2'b10, 1, 32'h500);
        step(); chk("R6", "load_grant", load_grant, 8'b0000_0001); @(negedge clk);

        // R7: older fence blocks, younger fence does not
        clear_all(); head = 3'd5;
        put(5, 2'b01, 1, 32'h10); put(6, 2'b11, 1, 0); put(7, 2'b01, 1, 32'h20);
        step();
        chk("R7", "load_grant", load_grant, 8'b0010_0000);
        chk("R9", "first_idx", first_idx, 5);
        @(negedge clk);

        // R10: other kinds and finished loads never granted
        clear_all();
        put(0, 2'b00, 1, 32'h10); put(1, 2'b01, 1, 32'h14); ent_done[1] = 1'b1;
        ent_kind[5:4] = 2'b01; ent_addr_ok[2] = 1'b1;
        step(); chk("R10", "load_grant", load_grant, 0); @(negedge clk);

        // Random buffers from a small address pool
        for (int n = 0; n < 400; n++) begin
            head = IDXW'($urandom);
            for (int i = 0; i < DEPTH; i++) begin
                ent_valid[i]   = ($urandom % 8) != 0;
                ent_kind[2*i +: 2] = ($urandom % 10 == 0) ? 2'b11 : 2'($urandom % 3);
                ent_addr_ok[i] = ($urandom % 4) != 0;
                ent_done[i]    = ($urandom % 6) == 0;
                ent_addr[i*AW +: AW] = 32'h1000 + 32'($urandom % 4) * 4 + 32'($urandom % 4);
            end
            model_check("R3/R5/R6/R7/R8/R9/R10");
        end

        // R1: reset clears outputs again
        rst_n = 1'b0;
        step();
        chk("R1", "load_grant", load_grant, 0);
        chk("R1", "agen_ok", agen_ok, 0);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule